// File: doc/BRIEF.md
# Rotating-Priority Interrupt Bus Arbiter

This block decides which of several interrupt controllers sharing a message bus receives a message. Every agent keeps a 4-bit arbitration priority. A caller presents a request mask and a start strobe; one clock later the arbiter reports the winning agent index together with a done strobe. In highest-wins mode the largest arbitration priority wins and all priorities then rotate: the winner falls to zero and every other agent steps up by one. An agent that has reached 15 takes the winner's old value plus one instead. In lowest-value mode the winner is chosen from a separate per-agent value supplied on an input bus, and no rotation takes place.

For a message addressed to several agents, the caller also raises the multi-winner flag. The arbiter then grants the requested agents one per clock, in arbitration order. Before each grant it repeats arbitration over the agents still waiting, and it rotates priorities after every grant. A synchronize command reloads every agent's arbitration priority from its index, whatever the mask holds. The current priorities are visible on an output bus so that the bus fabric can observe them.

Top module: `rot_prio_arb`

## Requirements
- R1: While reset is active and immediately after it, agent i holds arbitration priority i mod 16 (field i of `arb_prio_flat` is bits [4i+3:4i]), and `gnt_valid`, `done`, `none` and `busy` are 0.
- R2: A grant only ever names an agent whose bit is set in the request mask in force for that arbitration.
- R3: In highest-wins mode (`mode_low`=0) the requested agent with the largest arbitration priority wins. On a tie the lowest index wins.
- R4: In lowest-value mode (`mode_low`=1) the requested agent with the smallest value in `low_prio_flat` wins (field i at bits [4i+3:4i]). On a tie the lowest index wins. Arbitration priorities do not change.
- R5: After a highest-wins grant, the winner's arbitration priority is 0.
- R6: After a highest-wins grant, each other agent's priority becomes its old value plus one. If its old value was 15, it becomes the winner's old value plus one instead. Both results are taken modulo 16.
- R7: A single arbitration accepted at a clock edge shows `gnt_valid`, `gnt_idx` and `done` for one cycle after that edge. The updated priorities appear at the same time.
- R8: With `multi`=1 in highest-wins mode, the arbiter grants one requested agent per clock, each exactly once, in arbitration order over the agents not yet granted. Priorities rotate after every grant. `busy` stays high while grants remain, and `done` rises together with the last grant.
- R9: An accepted start with an empty mask produces `done` and `none` for one cycle, with no grant, and leaves the priorities unchanged.
- R10: A synchronize command accepted while idle loads every agent's priority with its index. A start in the same cycle is dropped.
- R11: While `busy` is high, `start` and `sync` are ignored.
- R12: With `multi`=1 in lowest-value mode, only a single winner is granted, as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an arbitration when idle |
| sync | input | 1 | Reload all priorities from agent indices when idle |
| mode_low | input | 1 | 0: highest arbitration priority wins; 1: lowest external value wins |
| multi | input | 1 | Grant every requested agent in sequence (highest-wins mode only) |
| req_mask | input | N_AGENTS | Agents taking part |
| low_prio_flat | input | 4*N_AGENTS | Per-agent value for lowest-value mode |
| gnt_valid | output | 1 | A grant is reported this cycle |
| gnt_idx | output | IDX_W | Index of the granted agent |
| done | output | 1 | Arbitration or sequence finished |
| none | output | 1 | Finished with no winner (empty mask) |
| busy | output | 1 | A multi-winner sequence has grants left |
| arb_prio_flat | output | 4*N_AGENTS | Current arbitration priorities |

## Verification
The bench drives one agent to win again and again, so that the other agents climb to 15 and must take the wrap rule. An arbiter that only increments would let them overflow to 0, and the priority bus would then drift from the model. Ties are built in both modes. A scan that lets an equal value replace the candidate would grant the higher index. It also applies empty masks, starts and syncs during a sequence, and a sync that coincides with a start. A sequencer that accepts those or rotates on an empty mask would show extra grants or moved priorities. A long random phase compares every output with a behavioural model on each clock.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  localparam int PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;

  // New arbitration priority of one agent after a highest-wins grant.
  function automatic prio_t rotate_one(prio_t own, prio_t win_old, logic is_win);
    prio_t r;
    if (is_win)             r = '0;
    else if (own == '1)     r = prio_t'(win_old + 1'b1);
    else                    r = prio_t'(own + 1'b1);
    return r;
  endfunction

  // Value an agent starts from after reset or a synchronize command.
  function automatic prio_t id_prio(int idx);
    return prio_t'(idx % (1 << PRIO_W));
  endfunction
endpackage

// File: rtl/rpa_scan.sv
module rpa_scan
  import rpa_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [N_AGENTS-1:0]        req,
  input  logic [N_AGENTS*PRIO_W-1:0] arb_prio,
  input  logic [N_AGENTS*PRIO_W-1:0] low_prio,
  input  logic                       pick_low,
  output logic                       found,
  output logic [IDX_W-1:0]           idx
);
  localparam logic [PRIO_W:0] CEIL = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W:0] best;
  logic [PRIO_W:0] val;
  logic            take;

  // Ascending scan: only a strictly better value replaces the candidate.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = pick_low ? CEIL : '0;
    val   = '0;
    take  = 1'b0;
    for (int i = 0; i < N_AGENTS; i++) begin
      val  = {1'b0, (pick_low ? low_prio[i*PRIO_W +: PRIO_W] : arb_prio[i*PRIO_W +: PRIO_W])};
      take = req[i] && (pick_low ? (val < best) : (!found || (val > best)));
      if (take) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = val;
      end
    end
  end
endmodule

// File: rtl/rpa_prio_bank.sv
module rpa_prio_bank
  import rpa_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_ids,
  input  logic                       rot_en,
  input  logic [IDX_W-1:0]           rot_idx,
  output logic [N_AGENTS*PRIO_W-1:0] prio_flat
);
  prio_t win_old;

  always_comb begin
    win_old = '0;
    for (int i = 0; i < N_AGENTS; i++)
      if (rot_idx == IDX_W'(i)) win_old = prio_flat[i*PRIO_W +: PRIO_W];
  end

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    localparam prio_t MY_ID = id_prio(g);
    prio_t cur;
    assign prio_flat[g*PRIO_W +: PRIO_W] = cur;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cur <= MY_ID;
      else if (load_ids) cur <= MY_ID;
      else if (rot_en)   cur <= rotate_one(cur, win_old, rot_idx == IDX_W'(g));
    end
  end
endmodule

// File: rtl/rot_prio_arb.sv
module rot_prio_arb
  import rpa_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       sync,
  input  logic                       mode_low,
  input  logic                       multi,
  input  logic [N_AGENTS-1:0]        req_mask,
  input  logic [N_AGENTS*PRIO_W-1:0] low_prio_flat,
  output logic                       gnt_valid,
  output logic [IDX_W-1:0]           gnt_idx,
  output logic                       done,
  output logic                       none,
  output logic                       busy,
  output logic [N_AGENTS*PRIO_W-1:0] arb_prio_flat
);
  logic [N_AGENTS-1:0] rem_q, rem_next, scan_req, win_bit;
  logic                busy_q, idle, acc_sync, acc_start, multi_go;
  logic                scan_low, found, grant_now, rot_en, last;
  logic [IDX_W-1:0]    win_idx;

  assign idle      = !busy_q;
  assign acc_sync  = sync && idle;
  assign acc_start = start && idle && !sync;
  assign multi_go  = acc_start && multi && !mode_low;
  assign scan_req  = busy_q ? rem_q : req_mask;
  assign scan_low  = busy_q ? 1'b0 : mode_low;

  rpa_scan #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_scan (
    .req      (scan_req),
    .arb_prio (arb_prio_flat),
    .low_prio (low_prio_flat),
    .pick_low (scan_low),
    .found    (found),
    .idx      (win_idx)
  );

  always_comb begin
    win_bit = '0;
    for (int i = 0; i < N_AGENTS; i++)
      if (win_idx == IDX_W'(i)) win_bit[i] = 1'b1;
  end

  assign grant_now = (busy_q || acc_start) && found;
  assign rot_en    = grant_now && !scan_low;
  assign rem_next  = scan_req & ~win_bit;
  assign last      = (rem_next == '0);

  rpa_prio_bank #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ids  (acc_sync),
    .rot_en    (rot_en),
    .rot_idx   (win_idx),
    .prio_flat (arb_prio_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      rem_q     <= '0;
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
      done      <= 1'b0;
      none      <= 1'b0;
    end else begin
      gnt_valid <= grant_now;
      if (grant_now) gnt_idx <= win_idx;
      none      <= acc_start && !found;
      done      <= (acc_start && (!found || !multi_go || last)) || (busy_q && last);
      if (busy_q)        busy_q <= !last;
      else               busy_q <= multi_go && found && !last;
      if (busy_q || multi_go) rem_q <= rem_next;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/rpa_checker.sv
module rpa_checker
  import rpa_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       sync,
  input logic                       mode_low,
  input logic                       multi,
  input logic [N_AGENTS-1:0]        req_mask,
  input logic                       gnt_valid,
  input logic [IDX_W-1:0]           gnt_idx,
  input logic                       done,
  input logic                       none,
  input logic                       busy,
  input logic [N_AGENTS*PRIO_W-1:0] arb_prio_flat,
  input logic                       rot_en,
  input logic [IDX_W-1:0]           win_idx
);
  function automatic logic [N_AGENTS*PRIO_W-1:0] ids_flat();
    logic [N_AGENTS*PRIO_W-1:0] f;
    for (int i = 0; i < N_AGENTS; i++) f[i*PRIO_W +: PRIO_W] = id_prio(i);
    return f;
  endfunction

  function automatic prio_t field(logic [N_AGENTS*PRIO_W-1:0] f, logic [IDX_W-1:0] ix);
    prio_t r;
    r = '0;
    for (int i = 0; i < N_AGENTS; i++)
      if (ix == IDX_W'(i)) r = f[i*PRIO_W +: PRIO_W];
    return r;
  endfunction

  localparam logic [N_AGENTS*PRIO_W-1:0] ID_FLAT = ids_flat();

  AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !$past(busy)) |-> ((($past(req_mask) >> gnt_idx) & 1) != 0)); // R2

  AST_WINNER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rot_en |=> (field(arb_prio_flat, $past(win_idx)) == '0)); // R5

  AST_LOW_NO_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !sync && mode_low) |=> $stable(arb_prio_flat)); // R4

  AST_SINGLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !sync && (mode_low || !multi)) |=> (done && !busy)); // R7

  AST_BUSY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> gnt_valid); // R8

  AST_NONE_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    none |-> (done && !gnt_valid)); // R9

  AST_NONE_KEEPS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    none |-> $stable(arb_prio_flat)); // R9

  AST_SYNC_LOADS_IDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !busy) |=> (arb_prio_flat == ID_FLAT)); // R10
endmodule

bind rot_prio_arb rpa_checker #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_rpa_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .sync          (sync),
  .mode_low      (mode_low),
  .multi         (multi),
  .req_mask      (req_mask),
  .gnt_valid     (gnt_valid),
  .gnt_idx       (gnt_idx),
  .done          (done),
  .none          (none),
  .busy          (busy),
  .arb_prio_flat (arb_prio_flat),
  .rot_en        (rot_en),
  .win_idx       (win_idx)
);

// File: tb/rot_prio_arb_tb_top.sv
`timescale 1ns/1ps
module rot_prio_arb_tb_top;
  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, sync = 1'b0, mode_low = 1'b0, multi = 1'b0;
  logic [N-1:0]  req_mask = '0;
  logic [N*4-1:0] low_prio_flat = '0;
  logic          gnt_valid, done, none, busy;
  logic [IW-1:0] gnt_idx;
  logic [N*4-1:0] arb_prio_flat;

  always #2.5 clk = ~clk;

  rot_prio_arb #(.N_AGENTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sync(sync), .mode_low(mode_low),
    .multi(multi), .req_mask(req_mask), .low_prio_flat(low_prio_flat),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .done(done), .none(none),
    .busy(busy), .arb_prio_flat(arb_prio_flat)
  );

  // ---------------- behavioural reference ----------------
  int m_prio[N];
  bit m_rem[N];
  bit m_busy, m_gv, m_done, m_none;
  int m_gi;
  int vectors = 0, fails = 0;
  string cur_tag = "R1";
  bit running = 1'b0;
  bit finished = 1'b0;

  function automatic int low_of(int i);
    return int'((low_prio_flat >> (4*i)) & 4'hF);
  endfunction

  // descending scans: ">=" / "<=" leave the lowest index on ties
  function automatic int pick_high(bit m[N]);
    int w = -1;
    for (int i = N-1; i >= 0; i--)
      if (m[i] && (w < 0 || m_prio[i] >= m_prio[w])) w = i;
    return w;
  endfunction

  function automatic int pick_low(bit m[N]);
    int w = -1;
    for (int i = N-1; i >= 0; i--)
      if (m[i] && (w < 0 || low_of(i) <= low_of(w))) w = i;
    return w;
  endfunction

  task automatic rotate(int w);
    int old_w = m_prio[w];
    for (int j = 0; j < N; j++) begin
      if (j == w)               m_prio[j] = 0;
      else if (m_prio[j] == 15) m_prio[j] = (old_w + 1) % 16;
      else                      m_prio[j] = m_prio[j] + 1;
    end
  endtask

  always @(posedge clk) begin
    bit m[N];
    int w, left;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_prio[i] = i % 16; m_rem[i] = 0; end
      m_busy = 0; m_gv = 0; m_done = 0; m_none = 0; m_gi = 0;
    end else begin
      m_gv = 0; m_done = 0; m_none = 0;
      if (m_busy) begin
        w = pick_high(m_rem);
        rotate(w); m_rem[w] = 0; m_gv = 1; m_gi = w;
        left = 0;
        for (int i = 0; i < N; i++) left += m_rem[i];
        if (left == 0) begin m_busy = 0; m_done = 1; end
      end else if (sync) begin
        for (int i = 0; i < N; i++) m_prio[i] = i % 16;
      end else if (start) begin
        for (int i = 0; i < N; i++) m = '{default:0};
        for (int i = 0; i < N; i++) m[i] = req_mask[i];
        if (req_mask == '0) begin
          m_done = 1; m_none = 1;
        end else if (mode_low) begin
          m_gi = pick_low(m); m_gv = 1; m_done = 1;
        end else begin
          w = pick_high(m); rotate(w); m_gv = 1; m_gi = w;
          if (multi) begin
            left = 0;
            for (int i = 0; i < N; i++) begin m_rem[i] = m[i] && (i != w); left += m_rem[i]; end
            if (left == 0) m_done = 1; else m_busy = 1;
          end else m_done = 1;
        end
      end
    end
  end

  task automatic miss(string what, int act, int exp);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_tag, what, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      vectors++;
      if (gnt_valid !== m_gv)  miss("gnt_valid", gnt_valid, m_gv);
      if (m_gv && gnt_idx !== IW'(m_gi)) miss("gnt_idx", gnt_idx, m_gi);
      if (done !== m_done)     miss("done", done, m_done);
      if (none !== m_none)     miss("none", none, m_none);
      if (busy !== m_busy)     miss("busy", busy, m_busy);
      for (int i = 0; i < N; i++)
        if (int'((arb_prio_flat >> (4*i)) & 4'hF) != m_prio[i])
          miss($sformatf("prio[%0d]", i), int'((arb_prio_flat >> (4*i)) & 4'hF), m_prio[i]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(bit st, bit sy, bit ml, bit mu, logic [N-1:0] mk);
    @(negedge clk); #1;
    start = st; sync = sy; mode_low = ml; multi = mu; req_mask = mk;
  endtask

  task automatic quiet(int k);
    drive(0, 0, 0, 0, '0);
    for (int i = 1; i < k; i++) @(negedge clk);
  endtask

  task automatic set_low(int a, int b, int c, int d);
    low_prio_flat = {4'(d), 4'(c), 4'(b), 4'(a)};
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    running = 1'b1;
    cur_tag = "R1";  // reset values checked by the compare on the first idle cycles
    quiet(2);

    cur_tag = "R3";  drive(1, 0, 0, 0, 4'b1111); quiet(2);   // R5 R6 R7 too
    cur_tag = "R2";  drive(1, 0, 0, 0, 4'b0101); quiet(1);
    cur_tag = "R10"; drive(0, 1, 0, 0, '0); quiet(1);
    cur_tag = "R6";  // agent 0 wins repeatedly: others climb to 15 then wrap
    for (int k = 0; k < 20; k++) begin drive(1, 0, 0, 0, 4'b0001); end
    quiet(1);
    cur_tag = "R3";  drive(1, 0, 0, 0, 4'b0110); drive(1, 0, 0, 0, 4'b1110); quiet(1);
    cur_tag = "R4";  set_low(5, 2, 2, 9); drive(1, 0, 1, 0, 4'b1111); quiet(1);
    set_low(0, 7, 7, 3); drive(1, 0, 1, 0, 4'b0110); quiet(1);
    cur_tag = "R9";  drive(1, 0, 0, 0, 4'b0000); drive(1, 0, 0, 1, 4'b0000); quiet(1);
    cur_tag = "R8";  drive(1, 0, 0, 1, 4'b1011); quiet(5);
    drive(1, 0, 0, 1, 4'b1111); quiet(6);
    drive(1, 0, 0, 1, 4'b0100); quiet(2);
    cur_tag = "R12"; set_low(4, 4, 1, 1); drive(1, 0, 1, 1, 4'b1111); quiet(2);
    cur_tag = "R11"; drive(1, 0, 0, 1, 4'b1111);
    drive(1, 0, 0, 0, 4'b0001); drive(0, 1, 0, 0, '0); drive(1, 1, 0, 0, 4'b0010);
    quiet(4);
    cur_tag = "R10"; drive(1, 1, 0, 0, 4'b1111); quiet(2);
    cur_tag = "R7";
    for (int k = 0; k < 600; k++) begin
      low_prio_flat = N*4'($urandom);
      drive($urandom_range(0, 1), ($urandom_range(0, 15) == 0), $urandom_range(0, 1),
            $urandom_range(0, 1), N'($urandom));
    end
    quiet(6);
    running = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule